// File: doc/BRIEF.md
# Keyboard Scancode Translator with Event Queue

This block sits between a keyboard front end that delivers PC set-1 scancode bytes and a CPU that reads key events over a 32-bit memory-mapped port. Shift and command keys are not stored as events. They update one latched modifier field, and a prefix byte of 0xE0 selects the right-hand command key. Every other byte is translated through a 128-entry keycode table, its release bit is kept, and the result is appended to a circular event queue.

The CPU pops events with word reads at offset 0x8. The modifier field is merged into each event when it is popped, not when it is queued. Release events read as zero. A word read at offset 0x0 and byte reads at offsets 0 to 2 return fixed status constants. Writes are accepted and have no effect. Responses come back registered, one cycle after the request.

Top module: `kbd_event_xlate`

## Requirements
- R1: A code byte of 0xE0 sets an extended flag. When 0x1D arrives with the flag set, the flag is cleared. A 0x36 byte also clears the flag. A 0x2A byte leaves the flag unchanged. The 0xE0 byte is itself also queued as an ordinary byte (see R4).
- R2: A 0x2A byte replaces the modifier field with bit 9 (left shift), and 0x36 replaces it with bit 10 (right shift). A 0x1D byte replaces it with bit 11 (left command) when the extended flag is clear, or with bit 12 (right command) when the flag is set. None of these bytes is queued.
- R3: A byte of 0xAA, 0x9D or 0xB6 clears the whole modifier field to zero and is not queued.
- R4: Any other byte is queued as the entry {byte[7], T(byte[6:0])}, where T(0)=0 and T(k)=(5k+3) mod 128 for k from 1 to 127.
- R5: The queue holds DEPTH (default 256) entries and returns them in FIFO order across pointer wrap. A byte that arrives while the queue is full is discarded. Fullness is judged before the cycle, so a pop in the same cycle does not make room.
- R6: A word read (size code 2) at offset 0x8 with a non-empty queue pops the oldest entry and forms v = entry | modifier field, using the modifier field as it stands in the pop cycle. If v[7] is set, the response is 0. Otherwise the response is 0x10008000 | v. A word read at 0x8 with an empty queue returns 0 and changes nothing.
- R7: A word read at offset 0x0 returns 0xA0F09300. Word reads at offsets 0x4 and 0xC return 0.
- R8: A byte read (size code 0) is decoded by the low two offset bits: 0 gives 0xA0, 1 gives 0xF0, 2 gives 0x13 and 3 gives 0. A halfword read (size code 1) returns 0. Neither kind of read pops the queue.
- R9: A write produces no response and does not pop the queue.
- R10: A read request accepted at one clock edge raises resp_valid with resp_data after that edge, for one cycle. resp_valid is low in cycles that follow no read.
- R11: Reset empties the queue and clears the modifier field and the extended flag.
- R12: If a byte is queued and a pop occurs in the same cycle, the count is unchanged and the pop returns the oldest entry present before that cycle. On an empty queue that pop returns 0, and the new entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | A scancode byte is present this cycle |
| code_byte | input | 8 | Scancode byte |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write (ignored), 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | 4 | Byte offset within the block |
| resp_valid | output | 1 | Read response valid |
| resp_data | output | 32 | Read response data |

## Verification
A scancode byte changes the queue or the modifier field at the first clock edge after it is presented. A read presented in the same cycle therefore still sees the state from before that edge. Read data and resp_valid are registered at the edge that accepts the request. The bench drives each request on a falling edge and samples the response on the next falling edge, exactly one edge later. For behaviour that leaves no direct trace, such as discards, unqueued modifiers and writes, the bench pops the queue afterwards until it reads empty. The sequence of values it gets back shows whether anything was added or removed.

// File: rtl/kbdx_pkg.sv
package kbdx_pkg;

    localparam int KEY_W  = 7;
    localparam int TBL_N  = 2 ** KEY_W;
    localparam int ENT_W  = KEY_W + 1;
    localparam int MOD_W  = 16;
    localparam int OFS_W  = 4;
    localparam int BUS_W  = 32;

    // modifier bit positions (visible in read data)
    localparam int MOD_LSHIFT = 9;
    localparam int MOD_RSHIFT = 10;
    localparam int MOD_LCMD   = 11;
    localparam int MOD_RCMD   = 12;

    // scancodes with special meaning
    localparam logic [7:0] SC_PREFIX  = 8'hE0;
    localparam logic [7:0] SC_LSHIFT  = 8'h2A;
    localparam logic [7:0] SC_RSHIFT  = 8'h36;
    localparam logic [7:0] SC_CMD     = 8'h1D;
    localparam logic [7:0] SC_LSHIFT_R = 8'hAA;
    localparam logic [7:0] SC_RSHIFT_R = 8'hB6;
    localparam logic [7:0] SC_CMD_R    = 8'h9D;

    // access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // read map
    localparam logic [OFS_W-1:0] OFS_STATUS = 4'h0;
    localparam logic [OFS_W-1:0] OFS_EVENT  = 4'h8;
    localparam logic [BUS_W-1:0] STATUS_WORD = 32'hA0F0_9300;
    localparam logic [7:0] STATUS_B0 = 8'hA0;
    localparam logic [7:0] STATUS_B1 = 8'hF0;
    localparam logic [7:0] STATUS_B2 = 8'h13;
    localparam logic [BUS_W-1:0] EVENT_TAG = 32'h1000_8000;

    // keycode translation entry, computed rather than listed
    function automatic logic [KEY_W-1:0] xlate_entry(input int idx);
        int v;
        if (idx == 0) begin
            v = 0;
        end else begin
            v = (5 * idx + 3) % TBL_N;
        end
        return KEY_W'(v);
    endfunction

endpackage

// File: rtl/kbdx_decode.sv
module kbdx_decode
    import kbdx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic [7:0]       code_byte,
    output logic             push_en,
    output logic [ENT_W-1:0] push_data,
    output logic [MOD_W-1:0] mod_bits
);

    typedef struct packed {
        logic             ext;
        logic [MOD_W-1:0] mods;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic [KEY_W-1:0] tbl [TBL_N];

    for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
        assign tbl[i] = xlate_entry(i);
    end

    always_comb begin
        st_d      = st_q;
        push_en   = 1'b0;
        push_data = {code_byte[7], tbl[code_byte[KEY_W-1:0]]};
        if (code_valid) begin
            if (code_byte == SC_PREFIX) begin
                st_d.ext = 1'b1;
            end
            case (code_byte)
                SC_LSHIFT: begin
                    st_d.mods = MOD_W'(1) << MOD_LSHIFT;
                end
                SC_RSHIFT: begin
                    st_d.mods = MOD_W'(1) << MOD_RSHIFT;
                    st_d.ext  = 1'b0;
                end
                SC_CMD: begin
                    if (st_q.ext) begin
                        st_d.mods = MOD_W'(1) << MOD_RCMD;
                        st_d.ext  = 1'b0;
                    end else begin
                        st_d.mods = MOD_W'(1) << MOD_LCMD;
                    end
                end
                SC_LSHIFT_R, SC_RSHIFT_R, SC_CMD_R: begin
                    st_d.mods = '0;
                end
                default: begin
                    push_en = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_bits = st_q.mods;

endmodule

// File: rtl/kbdx_fifo.sv
module kbdx_fifo #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    fifo_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_en && (st_q.cnt != FULL_CNT);
        do_pop  = pop_req && (st_q.cnt != '0);
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[st_q.wr_ptr] <= push_data;
        end
    end

    assign pop_data = mem[st_q.rd_ptr];
    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;

endmodule

// File: rtl/kbdx_readport.sv
module kbdx_readport
    import kbdx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [OFS_W-1:0] req_addr,
    input  logic             fifo_empty,
    input  logic [ENT_W-1:0] pop_data,
    input  logic [MOD_W-1:0] mod_bits,
    output logic             pop_req,
    output logic             resp_valid,
    output logic [BUS_W-1:0] resp_data
);

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } resp_t;

    resp_t rs_d, rs_q;
    logic             is_read;
    logic [MOD_W-1:0] merged;
    logic [BUS_W-1:0] event_word;
    logic [BUS_W-1:0] word_val;
    logic [7:0]       byte_val;

    always_comb begin
        is_read = req_valid && !req_write;
        pop_req = is_read && (req_size == SZ_WORD) && (req_addr == OFS_EVENT);

        merged = MOD_W'(pop_data) | mod_bits;
        if (fifo_empty || merged[7]) begin
            event_word = '0;
        end else begin
            event_word = EVENT_TAG | BUS_W'(merged);
        end

        case (req_addr)
            OFS_STATUS: word_val = STATUS_WORD;
            OFS_EVENT:  word_val = event_word;
            default:    word_val = '0;
        endcase

        case (req_addr[1:0])
            2'd0:    byte_val = STATUS_B0;
            2'd1:    byte_val = STATUS_B1;
            2'd2:    byte_val = STATUS_B2;
            default: byte_val = 8'h00;
        endcase

        rs_d.valid = is_read;
        rs_d.data  = '0;
        if (is_read) begin
            case (req_size)
                SZ_WORD: rs_d.data = word_val;
                SZ_BYTE: rs_d.data = BUS_W'(byte_val);
                default: rs_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign resp_valid = rs_q.valid;
    assign resp_data  = rs_q.data;

endmodule

// File: rtl/kbd_event_xlate.sv
module kbd_event_xlate
    import kbdx_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic [7:0]       code_byte,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [OFS_W-1:0] req_addr,
    output logic             resp_valid,
    output logic [BUS_W-1:0] resp_data
);

    logic             push_en;
    logic [ENT_W-1:0] push_data;
    logic [MOD_W-1:0] mod_bits;
    logic             pop_req;
    logic [ENT_W-1:0] pop_data;
    logic             fifo_empty;
    logic [CNT_W-1:0] fifo_count;

    kbdx_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code_byte  (code_byte),
        .push_en    (push_en),
        .push_data  (push_data),
        .mod_bits   (mod_bits)
    );

    kbdx_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (ENT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_data (push_data),
        .pop_req   (pop_req),
        .pop_data  (pop_data),
        .empty     (fifo_empty),
        .count     (fifo_count)
    );

    kbdx_readport u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .fifo_empty (fifo_empty),
        .pop_data   (pop_data),
        .mod_bits   (mod_bits),
        .pop_req    (pop_req),
        .resp_valid (resp_valid),
        .resp_data  (resp_data)
    );

endmodule

// File: rtl/kbdx_chk.sv
module kbdx_chk #(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_size,
    input logic [3:0]       req_addr,
    input logic             resp_valid,
    input logic [31:0]      resp_data,
    input logic             push_en,
    input logic             pop_req,
    input logic [15:0]      mod_bits,
    input logic [CNT_W-1:0] fifo_count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // R10
    resp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && !req_write));

    // R10
    read_gets_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> resp_valid);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FULL_CNT);

    // R5
    full_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == FULL_CNT && !pop_req) |=> fifo_count == FULL_CNT);

    // R12
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_req && fifo_count != '0 && fifo_count != FULL_CNT)
        |=> $stable(fifo_count));

    // R6
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fifo_count == '0) |=> resp_data == 32'h0);

    // R2
    mod_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_bits));

    // R7
    status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd2 && req_addr == 4'h0)
        |=> resp_data == 32'hA0F0_9300);

    // R9
    write_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !push_en) |=> $stable(fifo_count));

endmodule

bind kbd_event_xlate kbdx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .push_en    (push_en),
    .pop_req    (pop_req),
    .mod_bits   (mod_bits),
    .fifo_count (fifo_count)
);

// File: tb/kbd_event_xlate_test.sv
module kbd_event_xlate_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam logic [31:0] TAG = 32'h1000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic [7:0]  code_byte = 8'h00;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [3:0]  req_addr = 4'h0;
    logic        resp_valid;
    logic [31:0] resp_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;
    logic        got_v;
    logic [31:0] got_d;

    always #(CLK_PERIOD / 2) clk = ~clk;

    kbd_event_xlate #(.DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code_byte  (code_byte),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .resp_data  (resp_data)
    );

    function automatic logic [31:0] tval(input int k);
        return (k == 0) ? 32'd0 : 32'((5 * k + 3) % 128);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic pv, input logic [7:0] pc, input logic rv,
                        input logic rw, input logic [1:0] rs, input logic [3:0] ra);
        @(negedge clk);
        code_valid = pv; code_byte = pc;
        req_valid = rv; req_write = rw; req_size = rs; req_addr = ra;
        @(negedge clk);
        got_v = resp_valid; got_d = resp_data;
        code_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic push(input logic [7:0] c);
        step(1'b1, c, 1'b0, 1'b0, 2'd0, 4'h0);
    endtask

    task automatic rd(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, 8'h00, 1'b1, 1'b0, sz, a);
        check(got_v === 1'b1 && got_d === exp, tag, got_d, exp);
    endtask

    task automatic pop(input logic [31:0] exp, input string tag);
        rd(2'd2, 4'h8, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();

        // R11 reset state: empty queue, no response pending
        check(resp_valid === 1'b0, "R11 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        pop(32'h0, "R11 empty after reset");

        // R7 status words
        rd(2'd2, 4'h0, 32'hA0F0_9300, "R7 word at 0");
        rd(2'd2, 4'h4, 32'h0, "R7 word at 4");
        rd(2'd2, 4'hC, 32'h0, "R7 word at C");

        // R8 byte and halfword reads
        rd(2'd0, 4'h0, 32'hA0, "R8 byte 0");
        rd(2'd0, 4'h1, 32'hF0, "R8 byte 1");
        rd(2'd0, 4'h2, 32'h13, "R8 byte 2");
        rd(2'd0, 4'h3, 32'h00, "R8 byte 3");
        rd(2'd1, 4'h0, 32'h00, "R8 half 0");

        // R10 no response after idle cycle
        step(1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 4'h0);
        check(got_v === 1'b0, "R10 idle no resp", {31'd0, got_v}, 32'd0);

        // R8 R9: byte/half/write at event offset do not pop
        push(8'h13);
        rd(2'd0, 4'h8, 32'hA0, "R8 byte at 8");
        rd(2'd1, 4'h8, 32'h00, "R8 half at 8");
        step(1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 4'h8);
        check(got_v === 1'b0, "R9 write no resp", {31'd0, got_v}, 32'd0);
        pop(TAG | tval(8'h13), "R9 entry kept after write");
        pop(32'h0, "R9 queue then empty");

        // R4 sweep of all make codes, FIFO order
        for (int k = 0; k < 128; k++) begin
            if (k != 8'h1D && k != 8'h2A && k != 8'h36) push(8'(k));
        end
        for (int k = 0; k < 128; k++) begin
            if (k != 8'h1D && k != 8'h2A && k != 8'h36)
                pop(TAG | tval(k), $sformatf("R4 make 0x%02h", k));
        end
        pop(32'h0, "R4 empty after make sweep");

        // R4 R6 release codes read as zero but occupy entries
        for (int k = 128; k < 256; k++) begin
            if (k != 8'hAA && k != 8'h9D && k != 8'hB6) push(8'(k));
        end
        for (int k = 128; k < 256; k++) begin
            if (k != 8'hAA && k != 8'h9D && k != 8'hB6)
                pop(32'h0, $sformatf("R6 release 0x%02h", k));
        end
        push(8'h10);
        pop(TAG | tval(16), "R6 count exact after release sweep");

        // modifier behaviour from clean state
        do_reset();
        push(8'h2A); push(8'h10);
        pop(TAG | tval(16) | 32'h200, "R2 left shift bit 9");
        pop(32'h0, "R2 modifier not queued");
        push(8'hAA); push(8'h10);
        pop(TAG | tval(16), "R3 release clears field");
        pop(32'h0, "R3 release not queued");
        push(8'h36); push(8'h11);
        pop(TAG | tval(17) | 32'h400, "R2 right shift bit 10");
        push(8'hB6);
        push(8'h1D); push(8'h12);
        pop(TAG | tval(18) | 32'h800, "R2 left command bit 11");
        push(8'h9D);
        push(8'hE0); push(8'h1D); push(8'h12);
        pop(32'h0, "R1 prefix byte queued as release");
        pop(TAG | tval(18) | 32'h1000, "R1 prefixed command bit 12");
        push(8'h1D); push(8'h12);
        pop(TAG | tval(18) | 32'h800, "R1 flag cleared by command");
        push(8'hE0); push(8'h2A); push(8'h1D); push(8'h12);
        pop(32'h0, "R1 prefix entry");
        pop(TAG | tval(18) | 32'h1000, "R1 flag survives left shift");
        push(8'hE0); push(8'h36); push(8'h1D); push(8'h12);
        pop(32'h0, "R1 prefix entry 2");
        pop(TAG | tval(18) | 32'h800, "R1 right shift clears flag");
        push(8'h9D); push(8'h12); push(8'h2A);
        pop(TAG | tval(18) | 32'h200, "R6 modifier merged at pop time");
        push(8'h92);
        pop(32'h0, "R6 release with modifier reads zero");
        push(8'hAA);

        // R5 fill, discard on full, wrap
        for (int i = 0; i < DEPTH; i++) push(8'h01);
        push(8'h02);
        for (int i = 0; i < DEPTH; i++) pop(TAG | tval(1), "R5 full contents");
        pop(32'h0, "R5 overflow byte discarded");
        push(8'h03);
        pop(TAG | tval(3), "R5 after wrap");

        // R5 full with simultaneous pop still discards
        for (int i = 0; i < DEPTH; i++) push(8'h04);
        step(1'b1, 8'h05, 1'b1, 1'b0, 2'd2, 4'h8);
        check(got_d === (TAG | tval(4)), "R5 pop while full", got_d, TAG | tval(4));
        for (int i = 1; i < DEPTH; i++) pop(TAG | tval(4), "R5 drain");
        pop(32'h0, "R5 push during full pop dropped");

        // R12 simultaneous push and pop
        push(8'h06); push(8'h07);
        step(1'b1, 8'h08, 1'b1, 1'b0, 2'd2, 4'h8);
        check(got_d === (TAG | tval(6)), "R12 pop oldest", got_d, TAG | tval(6));
        pop(TAG | tval(7), "R12 second");
        pop(TAG | tval(8), "R12 pushed entry");
        pop(32'h0, "R12 count unchanged then empty");
        step(1'b1, 8'h05, 1'b1, 1'b0, 2'd2, 4'h8);
        check(got_v === 1'b1 && got_d === 32'h0, "R12 empty pop with push", got_d, 32'h0);
        pop(TAG | tval(5), "R12 entry kept");

        // R11 reset clears queue and modifier
        push(8'h2A); push(8'h10); push(8'h11);
        do_reset();
        pop(32'h0, "R11 queue cleared");
        push(8'h10);
        pop(TAG | tval(16), "R11 modifier cleared");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule